// File: doc/BRIEF.md
# Bend-Tolerant Track Pattern Detector

This block looks for track-shaped coincidences across four detector stations inside one zone. Each station delivers a strip-level hit vector. The block first folds neighbouring strip pairs into double strips, which halves the width that the pattern logic has to scan. Every double-strip position then acts as a key position, anchored on the second station.

For each key, a family of azimuthal patterns is tested. The patterns are indexed by bend: bend 0 is the narrow, straight pattern expected from high-momentum tracks. Each higher bend widens the search windows on the outer stations, up to a widest window of sixteen double strips on either side of the key at the first station. A pattern counts only when at least two stations see a hit. Its quality ranks patterns first by the number of stations hit, then by whether the first station is among them, and last by straightness. Each key position reports the quality and bend index of its best pattern.

The inputs are sampled on a strobe. The results appear in a register one cycle later, and a valid pulse marks that cycle. The results then hold until the next strobe.

Top module: `bend_pattern_detector`

## Requirements
- R1: After reset, every key position reports quality 0 and pattern ID 0, and `resultValid` is 0.
- R2: Strips 2k and 2k+1 of a station merge into double strip k. A hit on either strip of the pair is a hit on that double strip.
- R3: Let H(b) be the base reach of bend b, with H(0)=0 and H(b)=2^(b-1) otherwise.
  - Station 1 accepts hits within ±H(b) double strips of the key.
  - Station 2 accepts only the key itself.
  - Station 3 accepts hits within ±(H(b)>>2).
  - Station 4 accepts hits within ±(H(b)>>1).
  - Windows are clipped at the vector edges.
- R4: A pattern with fewer than two stations hit is invalid. If no bend at a key is valid, the key reports quality 0 and ID 0.
- R5: A valid pattern's 6-bit quality is built from three fields:
  - bits [5:4] hold the number of stations hit minus one;
  - bit [3] is set when station 1 is hit;
  - bits [2:0] hold NBEND-1-b.
- R6: Each key reports the bend with the highest quality. On equal quality, the lower bend index wins.
- R7: Results load on the clock edge that samples `strobe` high, and `resultValid` is high for exactly the following cycle. Without a strobe, the outputs hold their values even when the strip inputs change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | Sample the strip inputs and evaluate |
| stripSt1 | input | 2*NPOS | Station 1 strip hits |
| stripSt2 | input | 2*NPOS | Station 2 strip hits (key station) |
| stripSt3 | input | 2*NPOS | Station 3 strip hits |
| stripSt4 | input | 2*NPOS | Station 4 strip hits |
| quality | output | 6*NPOS | Best quality per key; key k at bits [6k+5:6k] |
| patternId | output | IDW*NPOS | Winning bend index per key; key k at bits [IDW*k +: IDW] |
| resultValid | output | 1 | High for the one cycle after a strobe |

## Verification
Every result is due one register after its strobe. The bench raises `strobe` on a falling edge and lets one rising edge capture it. It then reads quality, pattern ID and `resultValid` at the next falling edge. It also confirms that `resultValid` has dropped one cycle later. The hold checks change the strip inputs with the strobe low, wait several cycles, and then compare the outputs against the values from the previous strobe.

// File: rtl/pd_pkg.sv
package pd_pkg;

  localparam int QUAL_W = 6;

  typedef struct packed {
    logic capture;
    logic announce;
  } pdCtrl_t;

  // Window half-width in double strips for a station (0..3) and bend index
  function automatic int stationReach(int station, int bend);
    int base;
    base = (bend == 0) ? 0 : (1 << (bend - 1));
    case (station)
      0:       return base;
      1:       return 0;
      2:       return base >> 2;
      default: return base >> 1;
    endcase
  endfunction

endpackage

// File: rtl/pd_ctrl.sv
module pd_ctrl (
  input  logic             clk,
  input  logic             rstN,
  input  logic             strobe,
  output pd_pkg::pdCtrl_t  ctrl,
  output logic             resultValid
);

  logic validQ;

  always_comb begin
    ctrl.capture  = strobe;
    ctrl.announce = strobe;
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= ctrl.announce;
  end

  assign resultValid = validQ;

endmodule

// File: rtl/pd_key_eval.sv
module pd_key_eval #(
  parameter int NPOS  = 32,
  parameter int NBEND = 6,
  parameter int KEY   = 0,
  localparam int IDW   = (NBEND > 1) ? $clog2(NBEND) : 1,
  localparam int REACH = 1 << (NBEND - 2)
) (
  input  logic [4*NPOS-1:0]          diAll,
  output logic [pd_pkg::QUAL_W-1:0]  qual,
  output logic [IDW-1:0]             pid
);

  localparam int PADW = NPOS + 2 * REACH;

  logic [PADW-1:0]  pad  [4];
  logic [REACH:0]   near [4];
  logic [3:0]       stHit [NBEND];

  // Cumulative "any hit within distance d of the key" per station
  for (genvar s = 0; s < 4; s++) begin : g_station
    assign pad[s] = {{REACH{1'b0}}, diAll[s*NPOS +: NPOS], {REACH{1'b0}}};
    assign near[s][0] = pad[s][KEY + REACH];
    for (genvar d = 1; d <= REACH; d++) begin : g_dist
      assign near[s][d] = near[s][d-1] | pad[s][KEY + REACH - d] | pad[s][KEY + REACH + d];
    end
  end

  for (genvar b = 0; b < NBEND; b++) begin : g_bend
    for (genvar s = 0; s < 4; s++) begin : g_st
      localparam int R = pd_pkg::stationReach(s, b);
      assign stHit[b][s] = near[s][R];
    end
  end

  always_comb begin
    logic [2:0]                cnt;
    logic [1:0]                cntField;
    logic [pd_pkg::QUAL_W-1:0] cand;
    qual = '0;
    pid  = '0;
    for (int b = 0; b < NBEND; b++) begin
      cnt      = 3'($countones(stHit[b]));
      cntField = 2'(cnt - 3'd1);
      cand     = (cnt >= 3'd2) ? {cntField, stHit[b][0], 3'(NBEND - 1 - b)} : '0;
      if (cand > qual) begin
        qual = cand;
        pid  = IDW'(b);
      end
    end
  end

endmodule

// File: rtl/pd_datapath.sv
module pd_datapath #(
  parameter int NPOS  = 32,
  parameter int NBEND = 6,
  localparam int IDW   = (NBEND > 1) ? $clog2(NBEND) : 1,
  localparam int QW    = pd_pkg::QUAL_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pd_pkg::pdCtrl_t      ctrl,
  input  logic [2*NPOS-1:0]    stripSt1,
  input  logic [2*NPOS-1:0]    stripSt2,
  input  logic [2*NPOS-1:0]    stripSt3,
  input  logic [2*NPOS-1:0]    stripSt4,
  output logic [QW*NPOS-1:0]   quality,
  output logic [IDW*NPOS-1:0]  patternId
);

  logic [2*NPOS-1:0]   strips [4];
  logic [4*NPOS-1:0]   diAll;
  logic [QW*NPOS-1:0]  qualNext;
  logic [IDW*NPOS-1:0] idNext;

  assign strips[0] = stripSt1;
  assign strips[1] = stripSt2;
  assign strips[2] = stripSt3;
  assign strips[3] = stripSt4;

  for (genvar s = 0; s < 4; s++) begin : g_merge
    for (genvar k = 0; k < NPOS; k++) begin : g_pair
      assign diAll[s*NPOS + k] = strips[s][2*k] | strips[s][2*k+1];
    end
  end

  for (genvar k = 0; k < NPOS; k++) begin : g_key
    pd_key_eval #(.NPOS(NPOS), .NBEND(NBEND), .KEY(k)) u_eval (
      .diAll (diAll),
      .qual  (qualNext[k*QW +: QW]),
      .pid   (idNext[k*IDW +: IDW])
    );
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quality   <= '0;
      patternId <= '0;
    end else if (ctrl.capture) begin
      quality   <= qualNext;
      patternId <= idNext;
    end
  end

endmodule

// File: rtl/bend_pattern_detector.sv
module bend_pattern_detector #(
  parameter int NPOS  = 32,
  parameter int NBEND = 6,
  localparam int IDW   = (NBEND > 1) ? $clog2(NBEND) : 1,
  localparam int QW    = pd_pkg::QUAL_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 strobe,
  input  logic [2*NPOS-1:0]    stripSt1,
  input  logic [2*NPOS-1:0]    stripSt2,
  input  logic [2*NPOS-1:0]    stripSt3,
  input  logic [2*NPOS-1:0]    stripSt4,
  output logic [QW*NPOS-1:0]   quality,
  output logic [IDW*NPOS-1:0]  patternId,
  output logic                 resultValid
);

  pd_pkg::pdCtrl_t ctrl;

  pd_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .ctrl        (ctrl),
    .resultValid (resultValid)
  );

  pd_datapath #(.NPOS(NPOS), .NBEND(NBEND)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrl),
    .stripSt1  (stripSt1),
    .stripSt2  (stripSt2),
    .stripSt3  (stripSt3),
    .stripSt4  (stripSt4),
    .quality   (quality),
    .patternId (patternId)
  );

endmodule

// File: rtl/pd_checker.sv
module pd_checker #(
  parameter int NPOS  = 32,
  parameter int NBEND = 6,
  localparam int IDW   = (NBEND > 1) ? $clog2(NBEND) : 1,
  localparam int QW    = pd_pkg::QUAL_W
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 strobe,
  input logic [QW*NPOS-1:0]   quality,
  input logic [IDW*NPOS-1:0]  patternId,
  input logic                 resultValid
);

  // R7: the valid pulse follows every strobe
  a_r7_valid_after_strobe: assert property (@(posedge clk) disable iff (!rstN)
    strobe |=> resultValid);

  // R7: the valid pulse never appears without a strobe before it
  a_r7_valid_needs_strobe: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $past(strobe));

  // R7: the results hold while no strobe arrives
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe |=> ($stable(quality) && $stable(patternId)));

  for (genvar k = 0; k < NPOS; k++) begin : g_key
    // R4: a nonzero quality always means two or more stations were hit
    a_r4_min_two: assert property (@(posedge clk) disable iff (!rstN)
      (quality[k*QW +: QW] != '0) |-> (quality[k*QW + 4 +: 2] != 2'd0));

    // R4: an invalid key reports ID 0
    a_r4_zero_id: assert property (@(posedge clk) disable iff (!rstN)
      (quality[k*QW +: QW] == '0) |-> (patternId[k*IDW +: IDW] == '0));

    // R5: the straightness field agrees with the reported bend
    a_r5_rank_field: assert property (@(posedge clk) disable iff (!rstN)
      (quality[k*QW +: QW] != '0) |->
        (quality[k*QW +: 3] == 3'(NBEND - 1 - int'(patternId[k*IDW +: IDW]))));
  end

endmodule

bind bend_pattern_detector pd_checker #(.NPOS(NPOS), .NBEND(NBEND)) u_pd_checker (
  .clk         (clk),
  .rstN        (rstN),
  .strobe      (strobe),
  .quality     (quality),
  .patternId   (patternId),
  .resultValid (resultValid)
);

// File: tb/tb_bend_pattern_detector.sv
module tb_bend_pattern_detector;

  localparam int NPOS  = 32;
  localparam int NBEND = 6;
  localparam int IDW   = 3;
  localparam int QW    = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strobe = 1'b0;
  logic [2*NPOS-1:0] s1 = '0, s2 = '0, s3 = '0, s4 = '0;
  logic [QW*NPOS-1:0]  quality;
  logic [IDW*NPOS-1:0] patternId;
  logic resultValid;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  bend_pattern_detector #(.NPOS(NPOS), .NBEND(NBEND)) dut (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .stripSt1(s1), .stripSt2(s2), .stripSt3(s3), .stripSt4(s4),
    .quality(quality), .patternId(patternId), .resultValid(resultValid)
  );

  task automatic clearStrips();
    s1 = '0; s2 = '0; s3 = '0; s4 = '0;
  endtask

  task automatic fire();
    @(negedge clk); strobe = 1'b1;
    @(negedge clk); strobe = 1'b0;
  endtask

  task automatic checkKey(int key, int expQ, int expId, string tag);
    int q, id;
    q  = int'(quality[key*QW +: QW]);
    id = int'(patternId[key*IDW +: IDW]);
    nChecks++;
    if (q != expQ || id != expId) begin
      nFails++;
      $display("FAIL %s key %0d: quality %0d id %0d, expected quality %0d id %0d",
               tag, key, q, id, expQ, expId);
    end
  endtask

  task automatic checkBit(logic act, logic exp, string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  // R1: everything cleared after reset
  task automatic testReset();
    bit allZero;
    allZero = (quality == '0) && (patternId == '0);
    checkBit(allZero, 1'b1, "R1 outputs zero after reset");
    checkBit(resultValid, 1'b0, "R1 valid low after reset");
  endtask

  // R3/R5/R6/R4: a straight track centred on double strip 10
  task automatic testStraight();
    clearStrips();
    s1[20] = 1'b1; s2[21] = 1'b1; s3[20] = 1'b1; s4[21] = 1'b1;
    fire();
    checkBit(resultValid, 1'b1, "R7 valid one cycle after strobe");
    checkKey(10, 61, 0, "R5 straight four-station");
    checkKey(9, 42, 3, "R6 best bend beside key");
    checkKey(0, 0, 0, "R4 single station invalid");
    @(negedge clk);
    checkBit(resultValid, 1'b0, "R7 valid lasts one cycle");
  endtask

  // R3/R6: a bent track without station 1
  task automatic testBent();
    clearStrips();
    s2[40] = 1'b1; s3[45] = 1'b1;
    fire();
    checkKey(20, 17, 4, "R3 station 3 reach needs bend 4");
    checkKey(21, 0, 0, "R4 no key hit invalid");
  endtask

  // R2/R5: odd strip merge and station 1 flag
  task automatic testMergeAndFlag();
    clearStrips();
    s1[10] = 1'b1; s2[9] = 1'b1;
    fire();
    checkKey(4, 28, 1, "R2 odd strip merges into double strip 4");
    checkKey(5, 0, 0, "R4 station 2 absent at key 5");
  endtask

  // R3: windows clipped at both edges
  task automatic testEdges();
    clearStrips();
    s1[0] = 1'b1; s2[0] = 1'b1; s2[63] = 1'b1; s4[63] = 1'b1;
    fire();
    checkKey(0, 29, 0, "R3 low edge key");
    checkKey(31, 21, 0, "R3 high edge key");
    checkKey(30, 0, 0, "R3 near edge single station");
  endtask

  // R7: input changes without a strobe have no effect
  task automatic testHold();
    clearStrips();
    s1[20] = 1'b1; s2[21] = 1'b1; s3[20] = 1'b1; s4[21] = 1'b1;
    repeat (3) @(negedge clk);
    checkKey(0, 29, 0, "R7 hold key 0");
    checkKey(10, 0, 0, "R7 hold key 10");
    checkBit(resultValid, 1'b0, "R7 no valid without strobe");
    fire();
    checkKey(10, 61, 0, "R7 new strobe reloads");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testStraight();
    testBent();
    testMergeAndFlag();
    testEdges();
    testHold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

endmodule